// File: doc/BRIEF.md
# Dual-Output Banked Interrupt Controller

The controller gathers up to 64 level-sensitive, active-high interrupt sources and steers each of them to one of two processor interrupt lines: a normal line (`irq_o`) or a fast line (`fiq_o`). Sources are grouped in banks of 32. Each bank has its own enable mask and its own routing mask, and software can read a raw view and two masked views of that bank. Software reaches the registers through a simple 32-bit register bus with address, write enable, write data and combinational read data.

Nothing is latched. A source counts as pending only while its synchronized input is high, so the peripheral that raised the interrupt must also clear it. The `NUM_SRC` parameter selects a 32-source build with one bank or a 64-source build with two banks. In the 32-source build, the second bank's addresses behave as unmapped.

Top module: `dual_irq_router`

## Requirements
- R1: After reset, every enable and routing bit is 0. All sources are therefore masked and routed to the normal line, and both `irq_o` and `fiq_o` are 0 even if sources are high.
- R2: The enable registers (0x04 for sources 0-31, 0x24 for 32-63) and routing registers (0x08, 0x24+4 = 0x28) read back exactly the last value written. A read-modify-write of one bit changes only that bit, and the registers hold their value when no write is made.
- R3: The raw status registers (0x00 and 0x20) show the synchronized source levels, bit n of the bank being source n of that bank, with no latching. A source that drops reads back as 0.
- R4: The normal-line status (0x0C, 0x2C) equals raw AND enable AND NOT route. The fast-line status (0x10, 0x30) equals raw AND enable AND route. A route bit of 1 selects the fast line, and an enable bit of 0 masks the source.
- R5: `irq_o` is the OR of all normal-line status bits of every bank, and `fiq_o` is the OR of all fast-line status bits, each registered one clock after the status.
- R6: A source input passes a two-flop synchronizer. A change at the input shows in raw status after two rising clock edges and at `irq_o`/`fiq_o` after three.
- R7: Writes to raw and masked status addresses (0x00, 0x0C, 0x10, 0x20, 0x2C, 0x30) are ignored and change no register.
- R8: Unmapped addresses (any other offset, any misaligned address, and 0x20-0x30 in the 32-source build) read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt sources, active high |
| addr_i | input | ADDR_W | Register byte address |
| we_i | input | 1 | Write enable, sampled on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Registered normal interrupt line |
| fiq_o | output | 1 | Registered fast interrupt line |

## Verification
Four properties are checked on every cycle:
- Each output line equals the previous cycle's OR of its masked status.
- No masked status bit is set without its raw bit.
- No source is active on both lines at once.
- The enable and routing masks do not move without a write.

The bench scenarios are needed for the rest:
- The exact register map and read-back values.
- The three-edge input latency.
- Release of a dropped source.
- Ignored writes to read-only and unmapped addresses.
- The absence of the upper bank in the 32-source build, which is checked on a second instance.

// File: rtl/dual_irq_pkg.sv
package dual_irq_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned BANK_AW    = 5;   // 32-byte address window per bank

  typedef enum logic [2:0] {
    K_NONE,
    K_RAW,
    K_EN,
    K_SEL,
    K_IRQ,
    K_FIQ
  } reg_kind_e;

  function automatic reg_kind_e kind_of(input logic [BANK_AW-1:0] off);
    case (off)
      5'h00:   return K_RAW;
      5'h04:   return K_EN;
      5'h08:   return K_SEL;
      5'h0C:   return K_IRQ;
      5'h10:   return K_FIQ;
      default: return K_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dual_irq_sync.sv
module dual_irq_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dual_irq_decode.sv
module dual_irq_decode
  import dual_irq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_BANKS-1:0] bank_hit_o,
  output reg_kind_e            kind_o
);
  localparam int unsigned IDX_W = ADDR_W - BANK_AW;

  logic [IDX_W-1:0] idx;

  assign idx    = addr_i[ADDR_W-1:BANK_AW];
  assign kind_o = kind_of(addr_i[BANK_AW-1:0]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    assign bank_hit_o[b] = (idx == IDX_W'(b)) && (kind_o != K_NONE);
  end
endmodule

// File: rtl/dual_irq_bank.sv
module dual_irq_bank
  import dual_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] raw_i,
  input  logic             hit_i,
  input  logic             we_i,
  input  reg_kind_e        kind_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] en_o,
  output logic [REG_W-1:0] route_o,
  output logic [REG_W-1:0] irq_stat_o,
  output logic [REG_W-1:0] fiq_stat_o,
  output logic [REG_W-1:0] rdata_o
);
  logic [REG_W-1:0] en_q, route_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      route_q <= '0;
    end else if (hit_i && we_i) begin
      case (kind_i)
        K_EN:    en_q    <= wdata_i;
        K_SEL:   route_q <= wdata_i;
        default: ;  // status views are read-only
      endcase
    end
  end

  assign irq_stat_o = raw_i & en_q & ~route_q;
  assign fiq_stat_o = raw_i & en_q & route_q;
  assign en_o       = en_q;
  assign route_o    = route_q;

  always_comb begin
    rdata_o = '0;
    if (hit_i) begin
      case (kind_i)
        K_RAW:   rdata_o = raw_i;
        K_EN:    rdata_o = en_q;
        K_SEL:   rdata_o = route_q;
        K_IRQ:   rdata_o = irq_stat_o;
        K_FIQ:   rdata_o = fiq_stat_o;
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/dual_irq_router.sv
module dual_irq_router
  import dual_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 64,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int unsigned NUM_BANKS = NUM_SRC / REG_W;

  logic [NUM_SRC-1:0]   raw_all, en_all, route_all, irq_stat, fiq_stat;
  logic [NUM_BANKS-1:0] bank_hit;
  logic [REG_W-1:0]     bank_rd [NUM_BANKS];
  reg_kind_e            kind;
  logic                 irq_q, fiq_q;

  dual_irq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (src_i),
    .q_o    (raw_all)
  );

  dual_irq_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
    .addr_i     (addr_i),
    .bank_hit_o (bank_hit),
    .kind_o     (kind)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dual_irq_bank u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .raw_i      (raw_all[b*REG_W +: REG_W]),
      .hit_i      (bank_hit[b]),
      .we_i       (we_i),
      .kind_i     (kind),
      .wdata_i    (wdata_i),
      .en_o       (en_all[b*REG_W +: REG_W]),
      .route_o    (route_all[b*REG_W +: REG_W]),
      .irq_stat_o (irq_stat[b*REG_W +: REG_W]),
      .fiq_stat_o (fiq_stat[b*REG_W +: REG_W]),
      .rdata_o    (bank_rd[b])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) rdata_o |= bank_rd[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= |irq_stat;
      fiq_q <= |fiq_stat;
    end
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;
endmodule

// File: rtl/dual_irq_router_chk.sv
module dual_irq_router_chk #(
  parameter int unsigned NUM_SRC = 64
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic               irq_o,
  input logic               fiq_o,
  input logic [NUM_SRC-1:0] raw_all,
  input logic [NUM_SRC-1:0] en_all,
  input logic [NUM_SRC-1:0] route_all,
  input logic [NUM_SRC-1:0] irq_stat,
  input logic [NUM_SRC-1:0] fiq_stat
);
  p_irq_out_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|irq_stat));

  p_fiq_out_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o == $past(|fiq_stat));

  p_stat_subset_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((irq_stat | fiq_stat) & ~raw_all) == '0) && ((irq_stat & fiq_stat) == '0));

  p_en_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(en_all));

  p_route_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(route_all));
endmodule

bind dual_irq_router dual_irq_router_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .raw_all   (raw_all),
  .en_all    (en_all),
  .route_all (route_all),
  .irq_stat  (irq_stat),
  .fiq_stat  (fiq_stat)
);

// File: tb/dual_irq_router_tb.sv
`timescale 1ns/1ps
module dual_irq_router_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] src = '0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata32;
  logic        irq, fiq, irq32, fiq32;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #10 clk_i = ~clk_i;

  dual_irq_router #(.NUM_SRC(64)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  dual_irq_router #(.NUM_SRC(32)) u_dut_32 (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src[31:0]), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata32), .irq_o(irq32), .fiq_o(fiq32)
  );

  // {src, enable, route}
  localparam logic [191:0] VECS [0:5] = '{
    {64'h0000_0000_0000_00FF, 64'h0000_0000_0000_00F0, 64'h0000_0000_0000_0000},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hAAAA_AAAA_AAAA_AAAA},
    {64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000},
    {64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_0000_0000},
    {64'h1234_5678_9ABC_DEF0, 64'h0F0F_0F0F_0F0F_0F0F, 64'h00FF_00FF_00FF_00FF}
  };

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk_i);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] d32);
    @(negedge clk_i);
    addr = a;
    #1;
    d = rdata;
    d32 = rdata32;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] d, d32;
    logic [63:0] s, e, r, ei, ef;

    // R1: sources high during and after reset, all masked
    src = '1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    settle();
    chk("R1", "irq_o after reset", {63'd0, irq}, 64'd0);
    chk("R1", "fiq_o after reset", {63'd0, fiq}, 64'd0);
    rd(8'h04, d, d32); chk("R1", "enable lo", {32'd0, d}, 64'd0);
    rd(8'h24, d, d32); chk("R1", "enable hi", {32'd0, d}, 64'd0);
    rd(8'h08, d, d32); chk("R1", "route lo", {32'd0, d}, 64'd0);
    rd(8'h28, d, d32); chk("R1", "route hi", {32'd0, d}, 64'd0);
    rd(8'h0C, d, d32); chk("R1", "irq stat lo masked", {32'd0, d}, 64'd0);
    rd(8'h00, d, d32); chk("R3", "raw lo all high", {32'd0, d}, 64'hFFFF_FFFF);

    // Vector table: R3, R4, R5
    for (int i = 0; i < 6; i++) begin
      s = VECS[i][191:128]; e = VECS[i][127:64]; r = VECS[i][63:0];
      wr(8'h04, e[31:0]); wr(8'h24, e[63:32]);
      wr(8'h08, r[31:0]); wr(8'h28, r[63:32]);
      src = s;
      settle();
      ei = s & e & ~r;
      ef = s & e & r;
      rd(8'h00, d, d32); chk("R3", $sformatf("v%0d raw lo", i), {32'd0, d}, {32'd0, s[31:0]});
      rd(8'h20, d, d32); chk("R3", $sformatf("v%0d raw hi", i), {32'd0, d}, {32'd0, s[63:32]});
      rd(8'h0C, d, d32); chk("R4", $sformatf("v%0d irq lo", i), {32'd0, d}, {32'd0, ei[31:0]});
      chk("R4", $sformatf("v%0d irq lo 32b", i), {32'd0, d32}, {32'd0, ei[31:0]});
      rd(8'h2C, d, d32); chk("R4", $sformatf("v%0d irq hi", i), {32'd0, d}, {32'd0, ei[63:32]});
      rd(8'h10, d, d32); chk("R4", $sformatf("v%0d fiq lo", i), {32'd0, d}, {32'd0, ef[31:0]});
      rd(8'h30, d, d32); chk("R4", $sformatf("v%0d fiq hi", i), {32'd0, d}, {32'd0, ef[63:32]});
      chk("R5", $sformatf("v%0d irq_o", i), {63'd0, irq}, {63'd0, |ei});
      chk("R5", $sformatf("v%0d fiq_o", i), {63'd0, fiq}, {63'd0, |ef});
      chk("R5", $sformatf("v%0d irq_o 32b", i), {63'd0, irq32}, {63'd0, |ei[31:0]});
      chk("R5", $sformatf("v%0d fiq_o 32b", i), {63'd0, fiq32}, {63'd0, |ef[31:0]});
    end

    // R2: read-modify-write of one enable bit
    wr(8'h04, 32'h0000_00F0);
    rd(8'h04, d, d32);
    wr(8'h04, d | 32'h8);
    rd(8'h04, d, d32); chk("R2", "rmw enable lo", {32'd0, d}, 64'h0000_00F8);
    wr(8'h28, 32'hDEAD_BEEF);
    repeat (5) @(posedge clk_i);
    rd(8'h28, d, d32); chk("R2", "route hi hold", {32'd0, d}, 64'hDEAD_BEEF);

    // R6: latency, source 0 routed to normal line
    wr(8'h04, 32'h1); wr(8'h08, 32'h0); wr(8'h24, 32'h0);
    src = '0;
    settle();
    @(negedge clk_i); addr = 8'h00; src = 64'h1;
    @(posedge clk_i); #1;
    chk("R6", "raw after 1 edge", {63'd0, rdata[0]}, 64'd0);
    @(posedge clk_i); #1;
    chk("R6", "raw after 2 edges", {63'd0, rdata[0]}, 64'd1);
    chk("R6", "irq_o after 2 edges", {63'd0, irq}, 64'd0);
    @(posedge clk_i); #1;
    chk("R6", "irq_o after 3 edges", {63'd0, irq}, 64'd1);

    // R3: drop releases, no latching
    @(negedge clk_i); src = '0;
    settle();
    rd(8'h00, d, d32); chk("R3", "raw released", {32'd0, d}, 64'd0);
    chk("R3", "irq_o released", {63'd0, irq}, 64'd0);

    // R7: writes to read-only views ignored
    src = 64'h0000_0000_0000_0005;
    wr(8'h04, 32'h0000_0003);
    wr(8'h08, 32'h0000_0000);
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h2C, 32'hFFFF_FFFF); wr(8'h30, 32'hFFFF_FFFF);
    settle();
    rd(8'h00, d, d32); chk("R7", "raw lo unchanged", {32'd0, d}, 64'h5);
    rd(8'h04, d, d32); chk("R7", "enable lo unchanged", {32'd0, d}, 64'h3);
    rd(8'h08, d, d32); chk("R7", "route lo unchanged", {32'd0, d}, 64'h0);
    rd(8'h0C, d, d32); chk("R7", "irq lo unchanged", {32'd0, d}, 64'h1);
    rd(8'h24, d, d32); chk("R7", "enable hi unchanged", {32'd0, d}, 64'h0);

    // R8: unmapped and 32-source build upper bank
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h05, 32'hFFFF_FFFF);
    rd(8'h14, d, d32); chk("R8", "0x14 reads zero", {32'd0, d}, 64'd0);
    rd(8'h05, d, d32); chk("R8", "misaligned reads zero", {32'd0, d}, 64'd0);
    rd(8'h40, d, d32); chk("R8", "0x40 reads zero", {32'd0, d}, 64'd0);
    rd(8'h04, d, d32); chk("R8", "enable lo after unmapped writes", {32'd0, d}, 64'h3);
    rd(8'h08, d, d32); chk("R8", "route lo after unmapped writes", {32'd0, d}, 64'h0);
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, d, d32);
    chk("R8", "32b enable hi reads zero", {32'd0, d32}, 64'd0);
    chk("R2", "64b enable hi written", {32'd0, d}, 64'hFFFF_FFFF);
    rd(8'h20, d, d32); chk("R8", "32b raw hi reads zero", {32'd0, d32}, 64'd0);
    rd(8'h04, d, d32); chk("R8", "32b enable lo intact", {32'd0, d32}, 64'h3);

    done = 1'b1;
    summary();
  end
endmodule